// File: doc/BRIEF.md
# Multi-CPU Masked Interrupt Router

This block gathers 64 level-sensitive device interrupt lines into a registered raw request vector and routes them to four processors. Each processor owns a 64-bit enable mask. A processor's interrupt output is high whenever its mask and the raw vector share a set bit. A legacy cascaded-controller request is ORed onto one fixed raw bit, so that it can be masked like any other line.

Software reaches the router through a CSR port with a 32-bit data path. Each 64-bit register is moved in two halves through one shared 32-bit holding latch. A low-half write only loads the latch, and the matching high-half write commits the whole 64-bit value. A low-half read returns the low word and parks the high word in the latch, where the next high-half read picks it up. Some offsets exist but have no function here; they read as zero. Offsets that do not exist at all return all ones and flag an access error.

The CSR port is run by a two-state machine. In ST_IDLE no response is pending. Any accepted request takes the transition ACCEPT into ST_RESP, which presents the registered response for one cycle. From ST_RESP, a new request takes the transition CHAIN and stays in ST_RESP. With no request, the transition DRAIN returns the machine to ST_IDLE.

Top module: `irq_route_hub`

## Requirements
- R1: Each raw request bit is the level of its `dev_irq` line sampled at the previous rising clock edge. It rises and falls with the line, one cycle later.
- R2: `cpu_irq[i]` is high exactly when mask i AND the raw vector is nonzero. It reflects a changed raw bit or a committed mask from the edge at which that register changes.
- R3: `legacy_irq` is ORed into raw bit 55 (LEGACY_BIT) with the same one-cycle timing as R1.
- R4: Offset 0x300 reads the raw vector. Offsets 0x280, 0x2C0, 0x680 and 0x6C0 read mask AND raw for CPU 0, 1, 2 and 3. Writes to these five offsets change no register.
- R5: Offsets 0x200, 0x240, 0x600 and 0x640 hold the masks of CPU 0, 1, 2 and 3. They are readable and writable.
- R6: A write with address bit 2 clear loads only the holding latch and changes no mask. A write with address bit 2 set commits the value {wdata, latch} to the offset with bit 2 cleared. Only the committing write and the low-half read decode the offset.
- R7: A read with address bit 2 clear returns bits 31:0 of the register and loads bits 63:32 into the latch. A read with address bit 2 set returns the latch.
- R8: The offsets 0x000–0x1C0 (step 0x40), 0x340, 0x380, 0x3C0, 0x400–0x4C0, 0x580, 0x5C0, 0x700, 0x740, 0x780 and 0xC00–0xCC0 read as zero, ignore writes and raise no error.
- R9: Any other offset is undecoded. A low-half read of it returns 0xFFFFFFFF and pulses `csr_err`. A committing write to it pulses `csr_err` and changes no mask.
- R10: After reset the raw vector, all masks and the latch are zero, `cpu_irq` is all low, and no response is pending.
- R11: Every request accepted on a rising edge is answered by `csr_rvalid` high for exactly the following cycle. `csr_rdata` and `csr_err` are valid during that cycle, and `csr_rdata` is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 64 | Device interrupt levels |
| legacy_irq | input | 1 | Cascaded-controller interrupt level, folded onto raw bit 55 |
| csr_valid | input | 1 | CSR request strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte offset of the access |
| csr_wdata | input | 32 | Write data half-word |
| csr_rvalid | output | 1 | Response strobe, one cycle after the request |
| csr_rdata | output | 32 | Read data |
| csr_err | output | 1 | Access error, valid with csr_rvalid |
| cpu_irq | output | 4 | Per-CPU interrupt request |

## Verification
A wrong internal state shows at the ports within one or two cycles.

A mask holding the wrong bits makes `cpu_irq` differ as soon as a matching line is driven. It also makes the masked view read back the wrong word in the very next response.

A latch that commits too early or holds stale data only shows after a later access. Tests therefore pair each half-access with a read-back, and with a line stimulus that would expose a premature commit on `cpu_irq` one cycle later. Decode faults show in the first response, as a wrong value or a wrong error flag.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int LINE_W     = 64;
    localparam int HALF_W     = 32;
    localparam int N_CPU      = 4;
    localparam int ADDR_W     = 12;
    localparam int CPU_IDX_W  = $clog2(N_CPU);

    typedef enum logic [2:0] {
        RG_RAW,
        RG_MASK,
        RG_VIEW,
        RG_ZERO,
        RG_BAD
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [CPU_IDX_W-1:0]   cpu;
    } reg_sel_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

    // Offset decode on an address whose half-select bit is already cleared.
    // Registers sit on 0x40 boundaries; slot = offset / 0x40.
    function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_t   r;
        logic [5:0] slot;
        slot   = a[11:6];
        r.cpu  = {slot[4], slot[0]};
        r.kind = RG_BAD;
        if (a[5:0] == 6'd0) begin
            if (slot inside {6'd8, 6'd9, 6'd24, 6'd25})
                r.kind = RG_MASK;
            else if (slot inside {6'd10, 6'd11, 6'd26, 6'd27})
                r.kind = RG_VIEW;
            else if (slot == 6'd12)
                r.kind = RG_RAW;
            else if (slot inside {[6'd0:6'd7], [6'd13:6'd19], 6'd22, 6'd23,
                                  [6'd28:6'd30], [6'd48:6'd51]})
                r.kind = RG_ZERO;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture
    import irq_route_pkg::*;
#(
    parameter int W          = LINE_W,
    parameter int LEGACY_BIT = 55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    input  logic         legacy_i,
    output logic [W-1:0] raw_o
);

    logic [W-1:0] merged;
    logic [W-1:0] raw_q;

    // The legacy request shares its bit with the device line there.
    for (genvar b = 0; b < W; b++) begin : g_merge
        if (b == LEGACY_BIT) begin : g_leg
            assign merged[b] = lines_i[b] | legacy_i;
        end else begin : g_dev
            assign merged[b] = lines_i[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= merged;
    end

    assign raw_o = raw_q;

    AST_RAW_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (raw_o == $past(merged)));  // R1

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_route_pkg::*;
#(
    parameter int W    = LINE_W,
    parameter int NCPU = N_CPU
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              raw_i,
    input  logic [NCPU-1:0]           wr_en_i,
    input  logic [W-1:0]              wr_data_i,
    output logic [NCPU-1:0][W-1:0]    mask_o,
    output logic [NCPU-1:0]           irq_o
);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [W-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (!rst_n)          mask_q <= '0;
            else if (wr_en_i[c]) mask_q <= wr_data_i;
        end

        assign mask_o[c] = mask_q;
        assign irq_o[c]  = |(mask_q & raw_i);

        AST_ZERO_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i[c] && (wr_data_i == '0)) |=> !irq_o[c]);  // R2

        AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (raw_i != '0));  // R2
    end

    AST_ONE_MASK_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_i));  // R6

endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
    import irq_route_pkg::*;
#(
    parameter int W    = LINE_W,
    parameter int H    = HALF_W,
    parameter int AW   = ADDR_W,
    parameter int NCPU = N_CPU
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic                    write_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [H-1:0]            wdata_i,
    input  logic [W-1:0]            raw_i,
    input  logic [NCPU-1:0][W-1:0]  mask_i,
    output logic [NCPU-1:0]         mask_wr_o,
    output logic [W-1:0]            mask_wdata_o,
    output logic                    rvalid_o,
    output logic [H-1:0]            rdata_o,
    output logic                    err_o
);

    localparam logic [AW-1:0] HALF_SEL = AW'(4);

    port_state_e state_q, state_d;
    logic [H-1:0] latch_q, latch_d;
    logic [H-1:0] rdata_q, rdata_d;
    logic         err_q, err_d;

    reg_sel_t     sel;
    logic [W-1:0] full_val;
    logic         hi_half;

    assign hi_half = addr_i[2];
    assign sel     = decode_offset(addr_i & ~HALF_SEL);

    always_comb begin
        unique case (sel.kind)
            RG_RAW:  full_val = raw_i;
            RG_MASK: full_val = mask_i[sel.cpu];
            RG_VIEW: full_val = mask_i[sel.cpu] & raw_i;
            default: full_val = '0;
        endcase
    end

    // State register: ACCEPT / CHAIN to ST_RESP, DRAIN back to ST_IDLE.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = valid_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request handling: latch staging, commits, response data.
    always_comb begin
        latch_d      = latch_q;
        rdata_d      = '0;
        err_d        = 1'b0;
        mask_wr_o    = '0;
        mask_wdata_o = {wdata_i, latch_q};
        if (valid_i) begin
            if (write_i) begin
                if (!hi_half) begin
                    latch_d = wdata_i;
                end else if (sel.kind == RG_MASK) begin
                    mask_wr_o[sel.cpu] = 1'b1;
                end else if (sel.kind == RG_BAD) begin
                    err_d = 1'b1;
                end
            end else begin
                if (hi_half) begin
                    rdata_d = latch_q;
                end else if (sel.kind == RG_BAD) begin
                    rdata_d = '1;
                    err_d   = 1'b1;
                end else begin
                    rdata_d = full_val[H-1:0];
                    latch_d = full_val[W-1:H];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            latch_q <= latch_d;
            rdata_q <= rdata_d;
            err_q   <= err_d;
        end
    end

    // Output process.
    always_comb begin
        rvalid_o = 1'b0;
        rdata_o  = '0;
        err_o    = 1'b0;
        unique case (state_q)
            ST_RESP: begin
                rvalid_o = 1'b1;
                rdata_o  = rdata_q;
                err_o    = err_q;
            end
            default: ;
        endcase
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> rvalid_o);  // R11

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !rvalid_o);  // R11

    AST_LOW_WRITE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && !hi_half) |=> $stable(mask_i));  // R6

    AST_HI_READ_GIVES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !write_i && hi_half) |=> (rdata_o == $past(latch_q)));  // R7

    AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i) |=> (rdata_o == '0));  // R11

endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
    import irq_route_pkg::*;
#(
    parameter int LEGACY_BIT = 55
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINE_W-1:0]   dev_irq,
    input  logic                legacy_irq,
    input  logic                csr_valid,
    input  logic                csr_write,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [HALF_W-1:0]   csr_wdata,
    output logic                csr_rvalid,
    output logic [HALF_W-1:0]   csr_rdata,
    output logic                csr_err,
    output logic [N_CPU-1:0]    cpu_irq
);

    logic [LINE_W-1:0]             raw;
    logic [N_CPU-1:0][LINE_W-1:0]  masks;
    logic [N_CPU-1:0]              mask_wr;
    logic [LINE_W-1:0]             mask_wdata;

    irq_raw_capture #(.W(LINE_W), .LEGACY_BIT(LEGACY_BIT)) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (dev_irq),
        .legacy_i (legacy_irq),
        .raw_o    (raw)
    );

    irq_mask_bank #(.W(LINE_W), .NCPU(N_CPU)) u_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_i     (raw),
        .wr_en_i   (mask_wr),
        .wr_data_i (mask_wdata),
        .mask_o    (masks),
        .irq_o     (cpu_irq)
    );

    irq_csr_port #(.W(LINE_W), .H(HALF_W), .AW(ADDR_W), .NCPU(N_CPU)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (csr_valid),
        .write_i      (csr_write),
        .addr_i       (csr_addr),
        .wdata_i      (csr_wdata),
        .raw_i        (raw),
        .mask_i       (masks),
        .mask_wr_o    (mask_wr),
        .mask_wdata_o (mask_wdata),
        .rvalid_o     (csr_rvalid),
        .rdata_o      (csr_rdata),
        .err_o        (csr_err)
    );

    AST_LEGACY_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_irq |=> raw[LEGACY_BIT]);  // R3

    AST_RAW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_write && ((csr_addr & ~ADDR_W'(4)) == ADDR_W'(12'h300)))
            |=> $stable(masks));  // R4

    AST_ERR_ONLY_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        csr_err |-> csr_rvalid);  // R9

endmodule

// File: tb/sim_irq_route_hub.sv
`timescale 1ns/1ps
module sim_irq_route_hub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_irq = '0;
    logic        legacy_irq = 1'b0;
    logic        csr_valid = 1'b0;
    logic        csr_write = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_rvalid;
    logic [31:0] csr_rdata;
    logic        csr_err;
    logic [3:0]  cpu_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_route_hub u0 (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .legacy_irq(legacy_irq),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rvalid(csr_rvalid), .csr_rdata(csr_rdata),
        .csr_err(csr_err), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    logic [31:0] last_rd;
    logic        last_err;
    logic        last_rv;

    // One request, driven at a falling edge, response sampled one cycle later.
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = wr; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        last_rv = csr_rvalid; last_rd = csr_rdata; last_err = csr_err;
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic wr64(input logic [11:0] a, input logic [63:0] v);
        access(1'b1, a, v[31:0]);
        access(1'b1, a | 12'h4, v[63:32]);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10", "cpu_irq after reset", {28'd0, cpu_irq}, 32'd0);
        check("R10", "rvalid idle", {31'd0, csr_rvalid}, 32'd0);
        access(1'b0, 12'h300, 0);
        check("R10", "raw low", last_rd, 32'd0);
        access(1'b0, 12'h640, 0);
        check("R10", "mask3 low", last_rd, 32'd0);
        access(1'b0, 12'h644, 0);
        check("R10", "latch after mask3 read", last_rd, 32'd0);
    endtask

    task automatic t_mask_rw();
        wr64(12'h200, 64'h8000_0000_0000_00F0);
        check("R11", "write response valid", {31'd0, last_rv}, 32'd1);
        check("R11", "write rdata zero", last_rd, 32'd0);
        settle();
        check("R11", "rvalid single cycle", {31'd0, csr_rvalid}, 32'd0);
        access(1'b0, 12'h200, 0);
        check("R5", "mask0 low", last_rd, 32'h0000_00F0);
        check("R11", "read response valid", {31'd0, last_rv}, 32'd1);
        access(1'b0, 12'h204, 0);
        check("R7", "mask0 high via latch", last_rd, 32'h8000_0000);
        check("R2", "no irq with raw zero", {28'd0, cpu_irq}, 32'd0);
    endtask

    task automatic t_raw_and_view();
        @(negedge clk); dev_irq[4] = 1'b1;
        settle();
        check("R1", "irq after line rise", {28'd0, cpu_irq}, 32'h1);
        access(1'b0, 12'h300, 0);
        check("R4", "raw read", last_rd, 32'h10);
        access(1'b0, 12'h280, 0);
        check("R4", "view cpu0 low", last_rd, 32'h10);
        access(1'b0, 12'h2C0, 0);
        check("R4", "view cpu1 low", last_rd, 32'h0);
        @(negedge clk); dev_irq[63] = 1'b1;
        access(1'b0, 12'h280, 0);
        access(1'b0, 12'h284, 0);
        check("R7", "view cpu0 high", last_rd, 32'h8000_0000);
        @(negedge clk); dev_irq = '0;
        settle();
        check("R1", "irq after line fall", {28'd0, cpu_irq}, 32'h0);
        access(1'b0, 12'h300, 0);
        check("R1", "raw cleared", last_rd, 32'h0);
    endtask

    task automatic t_legacy();
        wr64(12'h600, 64'h0080_0000_0000_0000);
        @(negedge clk); legacy_irq = 1'b1;
        settle();
        check("R3", "legacy routes to cpu2", {28'd0, cpu_irq}, 32'h4);
        access(1'b0, 12'h300, 0);
        access(1'b0, 12'h304, 0);
        check("R3", "raw bit 55", last_rd, 32'h0080_0000);
        @(negedge clk); legacy_irq = 1'b0;
        settle();
        check("R3", "legacy drop", {28'd0, cpu_irq}, 32'h0);
    endtask

    task automatic t_ro_writes();
        wr64(12'h280, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4", "view write no err", {31'd0, last_err}, 32'd0);
        wr64(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        access(1'b0, 12'h200, 0);
        check("R4", "mask0 kept low", last_rd, 32'h0000_00F0);
        access(1'b0, 12'h204, 0);
        check("R4", "mask0 kept high", last_rd, 32'h8000_0000);
        access(1'b0, 12'h300, 0);
        check("R4", "raw unchanged", last_rd, 32'h0);
    endtask

    task automatic t_half_write();
        access(1'b1, 12'h240, 32'hFFFF_FFFF);
        @(negedge clk); dev_irq[0] = 1'b1;
        settle();
        check("R6", "low write no commit irq", {28'd0, cpu_irq}, 32'h0);
        access(1'b0, 12'h240, 0);
        check("R6", "mask1 still zero", last_rd, 32'h0);
        wr64(12'h240, 64'h1);
        check("R6", "commit sets cpu1", {28'd0, cpu_irq}, 32'h2);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    task automatic t_zero_offsets();
        wr64(12'h380, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8", "zero offset write no err", {31'd0, last_err}, 32'd0);
        access(1'b0, 12'h380, 0);
        check("R8", "zero offset read", last_rd, 32'h0);
        check("R8", "zero offset no err", {31'd0, last_err}, 32'd0);
        access(1'b0, 12'h384, 0);
        check("R8", "zero offset high", last_rd, 32'h0);
        access(1'b0, 12'hCC0, 0);
        check("R8", "zero offset 0xCC0", last_rd, 32'h0);
    endtask

    task automatic t_bad_offsets();
        access(1'b0, 12'h800, 0);
        check("R9", "bad read ones", last_rd, 32'hFFFF_FFFF);
        check("R9", "bad read err", {31'd0, last_err}, 32'd1);
        access(1'b0, 12'h208, 0);
        check("R9", "misaligned err", {31'd0, last_err}, 32'd1);
        access(1'b1, 12'h808, 32'h1234_5678);
        check("R6", "low write bad no err", {31'd0, last_err}, 32'd0);
        access(1'b1, 12'h80C, 32'h0);
        check("R9", "bad commit err", {31'd0, last_err}, 32'd1);
        access(1'b0, 12'h200, 0);
        check("R9", "mask0 after bad commit", last_rd, 32'h0000_00F0);
        settle();
        check("R11", "err cleared idle", {31'd0, csr_err}, 32'd0);
    endtask

    task automatic t_multi_cpu();
        wr64(12'h640, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk); dev_irq[10] = 1'b1;
        settle();
        check("R2", "cpu3 only", {28'd0, cpu_irq}, 32'h8);
        @(negedge clk); dev_irq[5] = 1'b1;
        settle();
        check("R2", "cpu3 and cpu0", {28'd0, cpu_irq}, 32'h9);
        access(1'b0, 12'h6C0, 0);
        check("R4", "view cpu3", last_rd, 32'h0000_0420);
        wr64(12'h640, 64'h0);
        check("R2", "mask clear drops cpu3", {28'd0, cpu_irq}, 32'h1);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_mask_rw();
        t_raw_and_view();
        t_legacy();
        t_ro_writes();
        t_half_write();
        t_zero_offsets();
        t_bad_offsets();
        t_multi_cpu();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule